// File: doc/BRIEF.md
# Prescaled Wait and Alarm Timer

This block gives a processor core two clocked countdown resources. The stall channel holds the core in a waiting state: while it is busy, the core's instruction sequencer must not advance, and normal cycling resumes once the count has elapsed. The alarm channel runs in the background while the core keeps executing. When its count elapses it raises an interrupt request that carries the interrupt number supplied when the channel was started.

Each channel is started by a one-cycle start pulse. The pulse carries a count operand and a resolution (prescale) operand. A resolution counter advances every clock cycle. When that counter has reached the resolution value, it drops back to zero and the main counter steps once, so one step takes resolution+1 cycles. When the main counter reaches the count operand, the channel finishes and goes idle. A count operand of zero never finishes. Each channel also has its own cancel input.

Top module: `wait_alarm_timer`

## Requirements
- R1: After reset, `wait_busy`, `alarm` and `alarm_irq` are all zero.
- R2: A `wait_go` pulse makes `wait_busy` read 1 in the cycle after the pulse.
- R3: With count N≠0 and resolution R, `wait_busy` stays high for exactly N·(R+1) cycles after the start edge and then drops.
- R4: With count N≠0 and resolution R, `alarm` rises exactly N·(R+1) cycles after the `alm_go` edge.
- R5: `alarm` is a single-cycle pulse.
- R6: While `alarm` is high, `alarm_irq` equals the `alm_irq` value captured by the latest `alm_go`. While `alarm` is low, `alarm_irq` reads 0.
- R7: A count operand of 0 never finishes. A stalled wait stays busy and the alarm never fires, even after the main counter has wrapped.
- R8: A cancel pulse without a start stops its channel. `wait_busy` is 0 in the next cycle, and an alarm that was cancelled does not fire.
- R9: A start pulse on a running channel clears both of its counters and loads the new operands. The finish time is measured from the new start, and the new interrupt number is used.
- R10: When start and cancel arrive together on the same channel, the start wins.
- R11: The two channels are independent. A running alarm channel never makes `wait_busy` rise, and the wait channel does not disturb the alarm timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wait_go | input | 1 | Start pulse for the stall channel |
| wait_count | input | CNT_W | Stall count operand (0 = endless) |
| wait_res | input | RES_W | Stall resolution operand |
| wait_stop | input | 1 | Cancel pulse for the stall channel |
| alm_go | input | 1 | Start pulse for the alarm channel |
| alm_count | input | CNT_W | Alarm count operand (0 = endless) |
| alm_res | input | RES_W | Alarm resolution operand |
| alm_irq | input | IRQ_W | Interrupt number latched at alarm start |
| alm_stop | input | 1 | Cancel pulse for the alarm channel |
| wait_busy | output | 1 | Core must stay in its waiting state |
| alarm | output | 1 | One-cycle interrupt request |
| alarm_irq | output | IRQ_W | Interrupt number accompanying `alarm` |

## Verification
The bench builds the block with CNT_W=8, RES_W=3 and IRQ_W=5. A 3-bit resolution lets every prescale value 0..7 be swept against several counts on both channels, so the N·(R+1) timing is checked arithmetically across the whole resolution range. The 8-bit count reaches its maximum of 255 in a short run. The same width lets the zero-count case wrap the main counter within a few hundred cycles, which shows that wrap-around never produces a completion. Restart, cancel and start-with-cancel collisions are timed against the same formula.

// File: rtl/wat_pkg.sv
package wat_pkg;

  localparam int unsigned DEF_CNT_W = 32;
  localparam int unsigned DEF_RES_W = 16;
  localparam int unsigned DEF_IRQ_W = 5;

  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_LOAD = 2'd1,
    CMD_STOP = 2'd2
  } chan_cmd_e;

  // start outranks cancel
  function automatic chan_cmd_e pick_cmd(input logic go, input logic stop);
    if (go)        return CMD_LOAD;
    else if (stop) return CMD_STOP;
    else           return CMD_IDLE;
  endfunction

endpackage

// File: rtl/wat_prescaler.sv
module wat_prescaler #(
  parameter int unsigned RES_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic [RES_W-1:0] res_val,
  output logic             tick
);

  logic [RES_W-1:0] div_q;

  // one tick every res_val+1 running cycles
  assign tick = run && (div_q >= res_val);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      div_q <= '0;
    end else if (run) begin
      if (tick) div_q <= '0;
      else      div_q <= div_q + 1'b1;
    end
  end

endmodule

// File: rtl/wat_core.sv
module wat_core
  import wat_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned RES_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             stop,
  input  logic [CNT_W-1:0] count,
  input  logic [RES_W-1:0] res,
  output logic             en_o,
  output logic             fire_o
);

  chan_cmd_e        cmd;
  logic             en_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic [RES_W-1:0] res_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             tick;
  logic             hit;

  assign cmd     = pick_cmd(go, stop);
  assign cnt_nxt = cnt_q + 1'b1;
  // zero limit: endless run
  assign hit     = (lim_q != '0) && (cnt_nxt >= lim_q);
  assign fire_o  = (cmd == CMD_IDLE) && tick && hit;
  assign en_o    = en_q;

  wat_prescaler #(.RES_W(RES_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .clr     (cmd != CMD_IDLE),
    .run     (en_q),
    .res_val (res_q),
    .tick    (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
      lim_q <= '0;
      res_q <= '0;
    end else begin
      unique case (cmd)
        CMD_LOAD: begin
          en_q  <= 1'b1;
          cnt_q <= '0;
          lim_q <= count;
          res_q <= res;
        end
        CMD_STOP: begin
          en_q  <= 1'b0;
          cnt_q <= '0;
        end
        default: begin
          if (tick) begin
            if (hit) begin
              en_q  <= 1'b0;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_nxt;
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/wat_alarm_stage.sv
module wat_alarm_stage #(
  parameter int unsigned IRQ_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [IRQ_W-1:0] irq_in,
  input  logic             fire,
  output logic             alarm_o,
  output logic [IRQ_W-1:0] alarm_irq_o
);

  logic [IRQ_W-1:0] irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q       <= '0;
      alarm_o     <= 1'b0;
      alarm_irq_o <= '0;
    end else begin
      if (go) irq_q <= irq_in;
      alarm_o     <= fire;
      alarm_irq_o <= fire ? irq_q : '0;
    end
  end

endmodule

// File: rtl/wait_alarm_timer.sv
module wait_alarm_timer
  import wat_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W,
  parameter int unsigned RES_W = DEF_RES_W,
  parameter int unsigned IRQ_W = DEF_IRQ_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wait_go,
  input  logic [CNT_W-1:0] wait_count,
  input  logic [RES_W-1:0] wait_res,
  input  logic             wait_stop,
  input  logic             alm_go,
  input  logic [CNT_W-1:0] alm_count,
  input  logic [RES_W-1:0] alm_res,
  input  logic [IRQ_W-1:0] alm_irq,
  input  logic             alm_stop,
  output logic             wait_busy,
  output logic             alarm,
  output logic [IRQ_W-1:0] alarm_irq
);

  logic unused_wait_fire;
  logic unused_alm_en;
  logic alm_fire;

  wat_core #(.CNT_W(CNT_W), .RES_W(RES_W)) u_wait (
    .clk    (clk),
    .rst    (rst),
    .go     (wait_go),
    .stop   (wait_stop),
    .count  (wait_count),
    .res    (wait_res),
    .en_o   (wait_busy),
    .fire_o (unused_wait_fire)
  );

  wat_core #(.CNT_W(CNT_W), .RES_W(RES_W)) u_alm (
    .clk    (clk),
    .rst    (rst),
    .go     (alm_go),
    .stop   (alm_stop),
    .count  (alm_count),
    .res    (alm_res),
    .en_o   (unused_alm_en),
    .fire_o (alm_fire)
  );

  wat_alarm_stage #(.IRQ_W(IRQ_W)) u_out (
    .clk         (clk),
    .rst         (rst),
    .go          (alm_go),
    .irq_in      (alm_irq),
    .fire        (alm_fire),
    .alarm_o     (alarm),
    .alarm_irq_o (alarm_irq)
  );

endmodule

// File: rtl/wat_checker.sv
module wat_checker #(
  parameter int unsigned IRQ_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             wait_go,
  input logic             wait_stop,
  input logic             alm_go,
  input logic             alm_stop,
  input logic [IRQ_W-1:0] alm_irq,
  input logic             wait_busy,
  input logic             alarm,
  input logic [IRQ_W-1:0] alarm_irq
);

  logic [IRQ_W-1:0] irq_ref;

  always_ff @(posedge clk) begin
    if (rst)         irq_ref <= '0;
    else if (alm_go) irq_ref <= alm_irq;
  end

  a_r2_busy_after_go: assert property (@(posedge clk) disable iff (rst)
    wait_go |=> wait_busy);

  a_r8_wait_cancel: assert property (@(posedge clk) disable iff (rst)
    (wait_stop && !wait_go) |=> !wait_busy);

  a_r8_alarm_cancel: assert property (@(posedge clk) disable iff (rst)
    (alm_stop && !alm_go) |=> !alarm);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    alarm |=> !alarm);

  a_r6_irq_tag: assert property (@(posedge clk) disable iff (rst)
    alarm |-> (alarm_irq == irq_ref));

  a_r6_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    !alarm |-> (alarm_irq == '0));

endmodule

bind wait_alarm_timer wat_checker #(.IRQ_W(IRQ_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wait_go   (wait_go),
  .wait_stop (wait_stop),
  .alm_go    (alm_go),
  .alm_stop  (alm_stop),
  .alm_irq   (alm_irq),
  .wait_busy (wait_busy),
  .alarm     (alarm),
  .alarm_irq (alarm_irq)
);

// File: tb/wait_alarm_timer_bench.sv
`timescale 1ns/1ps
module wait_alarm_timer_bench;

  localparam int CNT_W = 8;
  localparam int RES_W = 3;
  localparam int IRQ_W = 5;
  localparam int CAP   = 4000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wait_go = 1'b0, wait_stop = 1'b0;
  logic [CNT_W-1:0] wait_count = '0;
  logic [RES_W-1:0] wait_res = '0;
  logic             alm_go = 1'b0, alm_stop = 1'b0;
  logic [CNT_W-1:0] alm_count = '0;
  logic [RES_W-1:0] alm_res = '0;
  logic [IRQ_W-1:0] alm_irq = '0;
  logic             wait_busy, alarm;
  logic [IRQ_W-1:0] alarm_irq;

  int errs = 0;
  int checks = 0;

  always #5 clk = ~clk;

  wait_alarm_timer #(.CNT_W(CNT_W), .RES_W(RES_W), .IRQ_W(IRQ_W)) u_wait_alarm_timer (
    .clk(clk), .rst(rst),
    .wait_go(wait_go), .wait_count(wait_count), .wait_res(wait_res), .wait_stop(wait_stop),
    .alm_go(alm_go), .alm_count(alm_count), .alm_res(alm_res), .alm_irq(alm_irq),
    .alm_stop(alm_stop),
    .wait_busy(wait_busy), .alarm(alarm), .alarm_irq(alarm_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // count cycles of wait_busy high, starting at the negedge after the start edge
  task automatic measure_busy(input int exp, input string req);
    int len = 0;
    while (wait_busy && len < CAP) begin
      @(negedge clk);
      len++;
    end
    chk(len == exp, req, len, exp);
  endtask

  // latency to alarm from the negedge after the start edge; also checks tag and width
  task automatic measure_alarm(input int exp, input int irq, input string req);
    int lat = 0;
    bit busy_seen = 1'b0;
    while (!alarm && lat < CAP) begin
      if (wait_busy) busy_seen = 1'b1;
      @(negedge clk);
      lat++;
    end
    chk(lat == exp, req, lat, exp);
    chk(alarm_irq == IRQ_W'(irq), "R6", int'(alarm_irq), irq);
    chk(!busy_seen, "R11", int'(busy_seen), 0);
    @(negedge clk);
    chk(alarm == 1'b0, "R5", int'(alarm), 0);
    chk(alarm_irq == '0, "R6", int'(alarm_irq), 0);
  endtask

  task automatic start_wait(input int n, input int r, input bit with_stop);
    @(negedge clk);
    wait_go = 1'b1; wait_stop = with_stop;
    wait_count = CNT_W'(n); wait_res = RES_W'(r);
    @(negedge clk);
    wait_go = 1'b0; wait_stop = 1'b0;
  endtask

  task automatic start_alarm(input int n, input int r, input int irq, input bit with_stop);
    @(negedge clk);
    alm_go = 1'b1; alm_stop = with_stop;
    alm_count = CNT_W'(n); alm_res = RES_W'(r); alm_irq = IRQ_W'(irq);
    @(negedge clk);
    alm_go = 1'b0; alm_stop = 1'b0;
  endtask

  task automatic watch_no_alarm(input int cycles, input string req);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (alarm) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(wait_busy == 1'b0, "R1", int'(wait_busy), 0);
    chk(alarm == 1'b0, "R1", int'(alarm), 0);
    chk(alarm_irq == '0, "R1", int'(alarm_irq), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(wait_busy == 1'b0 && alarm == 1'b0, "R1", int'(wait_busy | alarm), 0);

    // R2, R3: wait sweep over counts and every resolution
    for (int n = 1; n <= 4; n++) begin
      for (int r = 0; r < 8; r++) begin
        start_wait(n, r, 1'b0);
        chk(wait_busy == 1'b1, "R2", int'(wait_busy), 1);
        measure_busy(n * (r + 1), "R3");
      end
    end
    start_wait(255, 0, 1'b0);
    measure_busy(255, "R3");

    // R4, R5, R6, R11: alarm sweep
    for (int n = 1; n <= 4; n++) begin
      for (int r = 0; r < 8; r++) begin
        start_alarm(n, r, (n * 8 + r) % 32, 1'b0);
        measure_alarm(n * (r + 1), (n * 8 + r) % 32, "R4");
      end
    end
    start_alarm(255, 0, 31, 1'b0);
    measure_alarm(255, 31, "R4");

    // R7: zero count never ends, even past counter wrap
    start_wait(0, 0, 1'b0);
    repeat (300) @(negedge clk);
    chk(wait_busy == 1'b1, "R7", int'(wait_busy), 1);
    @(negedge clk); wait_stop = 1'b1; @(negedge clk); wait_stop = 1'b0;
    chk(wait_busy == 1'b0, "R8", int'(wait_busy), 0);
    start_alarm(0, 0, 3, 1'b0);
    watch_no_alarm(600, "R7");
    @(negedge clk); alm_stop = 1'b1; @(negedge clk); alm_stop = 1'b0;

    // R8: cancel alarm mid-run
    start_alarm(4, 1, 12, 1'b0);
    repeat (3) @(negedge clk);
    alm_stop = 1'b1; @(negedge clk); alm_stop = 1'b0;
    watch_no_alarm(30, "R8");

    // R8: cancel wait mid-run
    start_wait(6, 3, 1'b0);
    repeat (5) @(negedge clk);
    wait_stop = 1'b1; @(negedge clk); wait_stop = 1'b0;
    chk(wait_busy == 1'b0, "R8", int'(wait_busy), 0);

    // R9: restart while running
    start_wait(5, 1, 1'b0);
    repeat (4) @(negedge clk);
    start_wait(3, 0, 1'b0);
    measure_busy(3, "R9");
    start_alarm(5, 1, 7, 1'b0);
    repeat (4) @(negedge clk);
    start_alarm(2, 2, 21, 1'b0);
    measure_alarm(6, 21, "R9");

    // R10: start and cancel together
    start_wait(2, 0, 1'b1);
    chk(wait_busy == 1'b1, "R10", int'(wait_busy), 1);
    measure_busy(2, "R10");
    start_alarm(1, 0, 9, 1'b1);
    measure_alarm(1, 9, "R10");

    // R11: wait runs inside a running alarm; alarm timing unchanged
    begin
      int lat = 0;
      start_alarm(20, 3, 17, 1'b0);
      @(negedge clk);
      wait_go = 1'b1; wait_count = CNT_W'(3); wait_res = '0;
      @(negedge clk);
      wait_go = 1'b0;
      lat = 2;
      measure_busy(3, "R11");
      lat += 3;
      while (!alarm && lat < CAP) begin
        @(negedge clk);
        lat++;
      end
      chk(lat == 80, "R11", lat, 80);
      chk(alarm_irq == IRQ_W'(17), "R11", int'(alarm_irq), 17);
    end

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule